// File: doc/BRIEF.md
# Maskable Interrupt Request Aggregator

This block gathers completion and status events from the sub-units of a contactless reader front end. It turns each event into a sticky request bit. The sources are a countdown timer, the transmitter, the receiver, the command sequencer, two FIFO fill-level alerts and a CRC coprocessor. Each request is raised by one specific hardware transition, which the block detects itself from the raw signals it watches. Examples are the timer stepping from one to zero, or the command code returning to idle.

Requests sit in two groups. The main group holds six bits. A second group holds the CRC request alone. Both groups feed one combined output pin and one global pending flag. A request counts toward the pin only when its enable bit is set. The host writes the enables and the pin polarity through a configuration port. It acknowledges a request by writing a one to that request's clear bit.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every request bit and every enable bit is 0, the polarity is active-low, `irq_pend_o` is 0 and `irq_pin_o` is 1.
- R2: Main bit 0 (timer) is set only when `tmr_val_i` held 1 in one cycle and 0 in the next cycle. All other pairs of consecutive values leave it unchanged.
- R3: Main bit 1 (transmit) is set when `tx_phase_i` goes from code 1 (sending data) to code 2 (sending end-of-frame). Codes 0 and 3 mean idle and reserved, and no other pair sets the bit.
- R4: Main bit 2 (receive) is set on a 0-to-1 transition of `rx_eod_i`.
- R5: Main bit 3 (idle) is set when `cmd_i` moves from a non-zero code to the idle code 0.
- R6: Main bit 4 (high alert) is set on the rising edge of the condition (64 − `fifo_lvl_i`) ≤ `water_i`. An alert that is already active when reset is released raises no request.
- R7: Main bit 5 (low alert) is set on the rising edge of the condition `fifo_lvl_i` ≤ `water_i`. It has the same reset rule as R6.
- R8: `req_crc_o` is a separate request group. It is set on a 0-to-1 transition of `crc_ready_i`, and a ready level that is already high at reset release raises no request.
- R9: Request bits are sticky. A 1 in `clr_main_i` or `clr_crc_i` clears that bit at the next edge, and bits written 0 keep their value.
- R10: When a set event and a clear hit the same bit in the same cycle, the bit is 1 afterwards.
- R11: `irq_pend_o` is 1 exactly when some request in either group has its enable bit set. The enables never alter the request bits.
- R12: `irq_pin_o` equals `irq_pend_o` when the stored polarity is 1, and equals its inverse when the polarity is 0.
- R13: On a cycle with `cfg_we_i` high, the enables and the polarity load from the cfg inputs. While `cfg_we_i` is low, changes on those inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_val_i | input | 16 | Current countdown timer value |
| tx_phase_i | input | 2 | Transmitter phase: 0 idle, 1 data, 2 end-of-frame, 3 reserved |
| rx_eod_i | input | 1 | Receiver end-of-data indication |
| cmd_i | input | 4 | Active command code, 0 is idle |
| fifo_lvl_i | input | 7 | FIFO fill level in bytes, 0 to 64 |
| water_i | input | 6 | FIFO alert threshold |
| crc_ready_i | input | 1 | CRC coprocessor ready level |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_main_i | input | 6 | Main-group enable write data |
| cfg_en_crc_i | input | 1 | CRC-group enable write data |
| cfg_pol_high_i | input | 1 | Pin polarity write data, 1 selects active-high |
| clr_main_i | input | 6 | Write-one-to-clear strobes for the main group |
| clr_crc_i | input | 1 | Write-one-to-clear strobe for the CRC request |
| req_main_o | output | 6 | Main-group request bits |
| req_crc_o | output | 1 | CRC-group request bit |
| irq_pend_o | output | 1 | Global pending flag |
| irq_pin_o | output | 1 | Interrupt pin with the selected polarity |

## Verification
The assertions assume that source inputs change only between clock edges. They also assume that a clear strobe is a single cycle wide and that the timer history since reset is meaningful. The timer property relies on the two values sampled before a rising request, so it takes the timer input during reset to reflect a real value. The stimulus drives every input just after the falling edge and holds it steady across the next rising edge. Between sweep points it returns each source to a neutral value before it clears the requests, so every transition under test starts from a known previous value.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;
  localparam int unsigned NUM_MAIN = 6;

  typedef enum int unsigned {
    SRC_TMR  = 0,
    SRC_TX   = 1,
    SRC_RX   = 2,
    SRC_IDLE = 3,
    SRC_HI   = 4,
    SRC_LO   = 5
  } main_src_e;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_DATA = 2'd1,
    TX_EOF  = 2'd2,
    TX_RSVD = 2'd3
  } tx_phase_e;
endpackage

// File: rtl/irq_fifo_alert.sv
`timescale 1ns/1ps
module irq_fifo_alert #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1),
  parameter int unsigned WL_W  = 6
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [WL_W-1:0]  water_i,
  output logic             hi_o,
  output logic             lo_o
);
  localparam int unsigned CW = ((LVL_W > WL_W) ? LVL_W : WL_W) + 1;

  logic [CW-1:0] lvl_x, wl_x, depth_x, room;

  assign lvl_x   = CW'(level_i);
  assign wl_x    = CW'(water_i);
  assign depth_x = CW'(DEPTH);
  // free space, saturating at zero for an out-of-range level
  assign room    = (lvl_x >= depth_x) ? '0 : depth_x - lvl_x;
  assign hi_o    = (room <= wl_x);
  assign lo_o    = (lvl_x <= wl_x);
endmodule

// File: rtl/irq_evt_detect.sv
`timescale 1ns/1ps
module irq_evt_detect
  import irq_agg_pkg::*;
#(
  parameter int unsigned             TMR_W    = 16,
  parameter int unsigned             CMD_W    = 4,
  parameter logic [CMD_W-1:0]        IDLE_CMD = '0,
  parameter int unsigned             DEPTH    = 64,
  parameter int unsigned             LVL_W    = $clog2(DEPTH + 1),
  parameter int unsigned             WL_W     = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TMR_W-1:0]    tmr_val_i,
  input  logic [1:0]          tx_phase_i,
  input  logic                rx_eod_i,
  input  logic [CMD_W-1:0]    cmd_i,
  input  logic [LVL_W-1:0]    fifo_lvl_i,
  input  logic [WL_W-1:0]     water_i,
  input  logic                crc_ready_i,
  output logic [NUM_MAIN-1:0] set_main_o,
  output logic                set_crc_o
);
  localparam logic [TMR_W-1:0] TMR_ONE  = TMR_W'(1);
  localparam logic [TMR_W-1:0] TMR_ZERO = '0;

  logic [TMR_W-1:0] tmr_q;
  logic [1:0]       tx_q;
  logic [CMD_W-1:0] cmd_q;
  logic             rx_q, hi_q, lo_q, crc_q;
  logic             hi_now, lo_now;

  irq_fifo_alert #(
    .DEPTH (DEPTH),
    .LVL_W (LVL_W),
    .WL_W  (WL_W)
  ) u_alert (
    .level_i (fifo_lvl_i),
    .water_i (water_i),
    .hi_o    (hi_now),
    .lo_o    (lo_now)
  );

  // alert and crc history start high: a level already active at reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      tx_q  <= TX_IDLE;
      rx_q  <= 1'b0;
      cmd_q <= IDLE_CMD;
      hi_q  <= 1'b1;
      lo_q  <= 1'b1;
      crc_q <= 1'b1;
    end else begin
      tmr_q <= tmr_val_i;
      tx_q  <= tx_phase_i;
      rx_q  <= rx_eod_i;
      cmd_q <= cmd_i;
      hi_q  <= hi_now;
      lo_q  <= lo_now;
      crc_q <= crc_ready_i;
    end
  end

  always_comb begin
    set_main_o           = '0;
    set_main_o[SRC_TMR]  = (tmr_q == TMR_ONE) && (tmr_val_i == TMR_ZERO);
    set_main_o[SRC_TX]   = (tx_q == TX_DATA) && (tx_phase_i == TX_EOF);
    set_main_o[SRC_RX]   = !rx_q && rx_eod_i;
    set_main_o[SRC_IDLE] = (cmd_q != IDLE_CMD) && (cmd_i == IDLE_CMD);
    set_main_o[SRC_HI]   = !hi_q && hi_now;
    set_main_o[SRC_LO]   = !lo_q && lo_now;
  end

  assign set_crc_o = !crc_q && crc_ready_i;
endmodule

// File: rtl/irq_req_bank.sv
`timescale 1ns/1ps
module irq_req_bank #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] req_o,
  output logic         hit_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic bit_q;
    // set outranks clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (set_i[g]) bit_q <= 1'b1;
      else if (clr_i[g]) bit_q <= 1'b0;
    end
    assign req_o[g] = bit_q;
  end

  assign hit_o = |(req_o & en_i);
endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned      TMR_W    = 16,
  parameter int unsigned      CMD_W    = 4,
  parameter logic [CMD_W-1:0] IDLE_CMD = '0,
  parameter int unsigned      DEPTH    = 64,
  parameter int unsigned      LVL_W    = $clog2(DEPTH + 1),
  parameter int unsigned      WL_W     = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TMR_W-1:0]    tmr_val_i,
  input  logic [1:0]          tx_phase_i,
  input  logic                rx_eod_i,
  input  logic [CMD_W-1:0]    cmd_i,
  input  logic [LVL_W-1:0]    fifo_lvl_i,
  input  logic [WL_W-1:0]     water_i,
  input  logic                crc_ready_i,
  input  logic                cfg_we_i,
  input  logic [NUM_MAIN-1:0] cfg_en_main_i,
  input  logic                cfg_en_crc_i,
  input  logic                cfg_pol_high_i,
  input  logic [NUM_MAIN-1:0] clr_main_i,
  input  logic                clr_crc_i,
  output logic [NUM_MAIN-1:0] req_main_o,
  output logic                req_crc_o,
  output logic                irq_pend_o,
  output logic                irq_pin_o
);
  logic [NUM_MAIN-1:0] set_main;
  logic                set_crc;
  logic [NUM_MAIN-1:0] en_main_q;
  logic                en_crc_q;
  logic                pol_high_q;
  logic                hit_main, hit_crc;

  irq_evt_detect #(
    .TMR_W    (TMR_W),
    .CMD_W    (CMD_W),
    .IDLE_CMD (IDLE_CMD),
    .DEPTH    (DEPTH),
    .LVL_W    (LVL_W),
    .WL_W     (WL_W)
  ) u_detect (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tmr_val_i   (tmr_val_i),
    .tx_phase_i  (tx_phase_i),
    .rx_eod_i    (rx_eod_i),
    .cmd_i       (cmd_i),
    .fifo_lvl_i  (fifo_lvl_i),
    .water_i     (water_i),
    .crc_ready_i (crc_ready_i),
    .set_main_o  (set_main),
    .set_crc_o   (set_crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_main_q  <= '0;
      en_crc_q   <= 1'b0;
      pol_high_q <= 1'b0;
    end else if (cfg_we_i) begin
      en_main_q  <= cfg_en_main_i;
      en_crc_q   <= cfg_en_crc_i;
      pol_high_q <= cfg_pol_high_i;
    end
  end

  irq_req_bank #(.W(NUM_MAIN)) u_main (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_main),
    .clr_i  (clr_main_i),
    .en_i   (en_main_q),
    .req_o  (req_main_o),
    .hit_o  (hit_main)
  );

  irq_req_bank #(.W(1)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_crc),
    .clr_i  (clr_crc_i),
    .en_i   (en_crc_q),
    .req_o  (req_crc_o),
    .hit_o  (hit_crc)
  );

  assign irq_pend_o = hit_main | hit_crc;
  assign irq_pin_o  = pol_high_q ? irq_pend_o : ~irq_pend_o;
endmodule

// File: rtl/irq_aggregator_chk.sv
`timescale 1ns/1ps
module irq_aggregator_chk #(
  parameter int unsigned TMR_W = 16,
  parameter int unsigned NM    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [TMR_W-1:0] tmr_val_i,
  input logic [NM-1:0]    clr_main_i,
  input logic             clr_crc_i,
  input logic [NM-1:0]    set_main,
  input logic             set_crc,
  input logic [NM-1:0]    en_main_q,
  input logic             en_crc_q,
  input logic [NM-1:0]    req_main_o,
  input logic             req_crc_o,
  input logic             irq_pend_o
);
  assert_timer_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_main_o[0]) |-> ($past(tmr_val_i) == '0 && $past(tmr_val_i, 2) == TMR_W'(1)));

  assert_crc_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_crc |=> req_crc_o);

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(req_main_o) & ~$past(clr_main_i)) & ~req_main_o) == '0));

  assert_crc_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_crc_o && !clr_crc_i) |=> req_crc_o);

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((req_main_o & $past(clr_main_i & ~set_main)) == '0));

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~req_main_o & $past(set_main)) == '0));

  assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((req_main_o & ~$past(req_main_o) & ~$past(set_main)) == '0));

  assert_pend_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pend_o == ((|(req_main_o & en_main_q)) | (req_crc_o & en_crc_q)));
endmodule

bind irq_aggregator irq_aggregator_chk #(.TMR_W(TMR_W), .NM(irq_agg_pkg::NUM_MAIN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tmr_val_i  (tmr_val_i),
  .clr_main_i (clr_main_i),
  .clr_crc_i  (clr_crc_i),
  .set_main   (set_main),
  .set_crc    (set_crc),
  .en_main_q  (en_main_q),
  .en_crc_q   (en_crc_q),
  .req_main_o (req_main_o),
  .req_crc_o  (req_crc_o),
  .irq_pend_o (irq_pend_o)
);

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr = '0;
  logic [1:0]  tx = '0;
  logic        rx = 1'b0;
  logic [3:0]  cmd = '0;
  logic [6:0]  lvl = 7'd32;
  logic [5:0]  wl = 6'd8;
  logic        crc = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_en_main = '0;
  logic        cfg_en_crc = 1'b0;
  logic        cfg_pol = 1'b0;
  logic [5:0]  clr_main = '0;
  logic        clr_crc = 1'b0;
  logic [5:0]  req_main;
  logic        req_crc, pend, pin;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .tmr_val_i      (tmr),
    .tx_phase_i     (tx),
    .rx_eod_i       (rx),
    .cmd_i          (cmd),
    .fifo_lvl_i     (lvl),
    .water_i        (wl),
    .crc_ready_i    (crc),
    .cfg_we_i       (cfg_we),
    .cfg_en_main_i  (cfg_en_main),
    .cfg_en_crc_i   (cfg_en_crc),
    .cfg_pol_high_i (cfg_pol),
    .clr_main_i     (clr_main),
    .clr_crc_i      (clr_crc),
    .req_main_o     (req_main),
    .req_crc_o      (req_crc),
    .irq_pend_o     (pend),
    .irq_pin_o      (pin)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_main = '1;
    clr_crc  = 1'b1;
    tick();
    clr_main = '0;
    clr_crc  = 1'b0;
  endtask

  task automatic trigger_all();
    tmr = 16'd1; tick(); tmr = 16'd0; tick();
    tx = 2'd1; tick(); tx = 2'd2; tick(); tx = 2'd0; tick();
    rx = 1'b1; tick(); rx = 1'b0;
    cmd = 4'd5; tick(); cmd = 4'd0; tick();
    lvl = 7'd62; tick(); lvl = 7'd2; tick(); lvl = 7'd32; tick();
    crc = 1'b0; tick(); crc = 1'b1; tick(); crc = 1'b0; tick();
  endtask

  task automatic write_cfg(input logic [5:0] em, input logic ec, input logic pol);
    cfg_we = 1'b1; cfg_en_main = em; cfg_en_crc = ec; cfg_pol = pol;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 req_main", int'(req_main), 0);
    chk("R1 req_crc", int'(req_crc), 0);
    chk("R1 pend", int'(pend), 0);
    chk("R1 pin", int'(pin), 1);

    // R2 timer: all pairs of consecutive values 0..3
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        tmr = 16'(a); tick(); clear_all();
        tmr = 16'(b); tick();
        chk($sformatf("R2 tmr %0d->%0d", a, b), int'(req_main[0]), int'(a == 1 && b == 0));
      end
    tmr = '0; tick(); clear_all();

    // R3 transmit phase pairs
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        tx = 2'(a); tick(); clear_all();
        tx = 2'(b); tick();
        chk($sformatf("R3 tx %0d->%0d", a, b), int'(req_main[1]), int'(a == 1 && b == 2));
      end
    tx = '0; tick(); clear_all();

    // R4 receive edges
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++) begin
        rx = 1'(a); tick(); clear_all();
        rx = 1'(b); tick();
        chk($sformatf("R4 rx %0d->%0d", a, b), int'(req_main[2]), int'(a == 0 && b == 1));
      end
    rx = 1'b0; tick(); clear_all();

    // R5 command codes, every pair
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        cmd = 4'(a); tick(); clear_all();
        cmd = 4'(b); tick();
        chk($sformatf("R5 cmd %0d->%0d", a, b), int'(req_main[3]), int'(a != 0 && b == 0));
      end
    cmd = '0; tick(); clear_all();

    // R6 R7 fifo alerts: sweep level from a neutral base for several thresholds
    for (int wi = 0; wi < 3; wi++) begin
      int w;
      w = (wi == 0) ? 0 : (wi == 1) ? 8 : 20;
      wl = 6'(w);
      for (int t = 0; t <= 64; t++) begin
        lvl = 7'd32; tick(); tick(); clear_all();
        lvl = 7'(t); tick();
        chk($sformatf("R6 hi w=%0d lvl=%0d", w, t), int'(req_main[4]), int'((64 - t) <= w));
        chk($sformatf("R7 lo w=%0d lvl=%0d", w, t), int'(req_main[5]), int'(t <= w));
      end
    end
    wl = 6'd8; lvl = 7'd32; tick(); tick(); clear_all();

    // R8 crc group
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++) begin
        crc = 1'(a); tick(); clear_all();
        crc = 1'(b); tick();
        chk($sformatf("R8 crc %0d->%0d", a, b), int'(req_crc), int'(a == 0 && b == 1));
        chk("R8 main untouched", int'(req_main), 0);
      end
    crc = 1'b0; tick(); clear_all();

    // R9 write-one-to-clear and stickiness
    trigger_all();
    chk("R9 all set", int'(req_main), 63);
    chk("R9 crc set", int'(req_crc), 1);
    clr_main = 6'b010101; tick(); clr_main = '0;
    chk("R9 partial clear", int'(req_main), 6'b101010);
    tick(); tick();
    chk("R9 sticky", int'(req_main), 6'b101010);
    chk("R9 crc sticky", int'(req_crc), 1);
    clr_crc = 1'b1; tick(); clr_crc = 1'b0;
    chk("R9 crc clear", int'(req_crc), 0);
    clear_all();

    // R10 set beats clear
    rx = 1'b1; clr_main = 6'b000100; tick(); clr_main = '0; rx = 1'b0;
    chk("R10 set wins", int'(req_main[2]), 1);
    tick(); clear_all();

    // R11 R12 request pattern x enable sweep, polarity alternating
    for (int p = 0; p < 128; p++) begin
      bit pol;
      pol = p[0];
      clear_all(); trigger_all();
      clr_main = ~6'(p); clr_crc = ~p[6]; tick(); clr_main = '0; clr_crc = 1'b0;
      chk("R11 req pattern", int'({req_crc, req_main}), p);
      for (int e = 0; e < 128; e++) begin
        int exp_pend;
        write_cfg(6'(e), e[6], pol);
        exp_pend = int'((p & e) != 0);
        chk($sformatf("R11 pend p=%0d e=%0d", p, e), int'(pend), exp_pend);
        chk($sformatf("R12 pin pol=%0d", pol), int'(pin), pol ? exp_pend : 1 - exp_pend);
      end
      chk("R11 enables leave requests", int'({req_crc, req_main}), p);
    end

    // R13 config ignored without write strobe
    clear_all(); trigger_all();
    write_cfg(6'd0, 1'b0, 1'b0);
    cfg_en_main = '1; cfg_en_crc = 1'b1; cfg_pol = 1'b1;
    tick(); tick();
    chk("R13 no write pend", int'(pend), 0);
    chk("R13 no write pin", int'(pin), 1);
    write_cfg(6'd0, 1'b1, 1'b1);
    chk("R13 write pend", int'(pend), 1);
    chk("R13 write pin", int'(pin), 1);

    done = 1'b1;
    finish_run();
  end
endmodule